// File: doc/BRIEF.md
# Block Copy DMA Engine

This engine copies a run of data words from one address range to another so the processor does not have to move them itself. Software programs a descriptor through a small register port. The descriptor holds the source address, the destination address, the word count and the address-stepping direction. Software then writes a start command. The engine asks the processor for the system bus and moves each word as a read followed by a write of the same data. When the last word is written, it raises a sticky interrupt.

The engine shares the bus under one of three policies, chosen in the control register:

- **Hold:** the bus is kept for the whole block.
- **Steal:** the bus is returned after every word.
- **Idle-slot:** an access is made only in cycles where the processor reports that it is not using the bus.

Address translation and access protection are not part of this block.

Top module: `dma_mover`

## Requirements
- R1: The register port maps source address at offset 0, destination address at offset 1, word count at offset 2, control at offset 3 and status at offset 4. Reading offsets 0 to 2 returns the last value written, zero-extended.
- R2: Writing the descriptor registers alone causes no bus request and no memory access.
- R3: In hold policy (control bits [3:2] = 0, or the reserved value 3), the bus request stays high from the start until the final word is written.
- R4: In steal policy (control bits [3:2] = 1), the bus request drops for at least one cycle after each word write. A block of N words therefore raises the request N times.
- R5: In idle-slot policy (control bits [3:2] = 2), no memory read or write is driven in a cycle where cpu_busy is high.
- R6: Completion of the last word sets status bit 1 and the irq output. The bit stays set until software writes 1 to status bit 1.
- R7: A start with a word count of zero sets the interrupt on the next clock edge and makes no bus request and no memory access.
- R8: With control bit 1 = 0, source and destination both step by one per word. With control bit 1 = 1, the source stays fixed and only the destination steps.
- R9: Once raised, the bus request stays high until bus_gnt is seen. No memory read or write is driven while bus_gnt is low.
- R10: Status bit 0 (busy) reads 1 from the cycle after an accepted start until the last word completes, and 0 otherwise. It is 0 after reset, as are the irq output and bus_req.
- R11: A control write while busy is ignored, including its start bit (control bit 0). The running block and the control readback stay unchanged.
- R12: Each word is one read cycle at the current source address, followed by a write of exactly that data at the current destination address. A block of N words makes exactly N reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr, combinational |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| cpu_busy | input | 1 | Processor is using the bus this cycle |
| mem_rd | output | 1 | Memory read strobe; data returns in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench drives a grant that lags the request by a cycle. It also holds grant low for a while. An engine that does not wait for grant would then show reads with no grant, and one that drops the request early would stall forever.

The processor-busy pattern in idle-slot runs lets a controller that ignores cpu_busy touch memory in busy cycles. Counting request rises separates a hold engine that lets go mid-block from a steal engine that never lets go.

A zero count, a fixed source and a start written mid-transfer target the failure modes of their own requirements:
- a zero-count start that is not trapped would cause a wrap to a 256-word copy;
- a fixed-source run with stepping still on would copy a ramp;
- a start accepted while busy would restart or reconfigure the block.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
   // bus sharing policies, control bits [3:2]
   localparam logic [1:0] XFER_HOLD    = 2'd0;
   localparam logic [1:0] XFER_STEAL   = 2'd1;
   localparam logic [1:0] XFER_IDLECYC = 2'd2;

   // register offsets
   localparam logic [2:0] REG_SRC  = 3'd0;
   localparam logic [2:0] REG_DST  = 3'd1;
   localparam logic [2:0] REG_LEN  = 3'd2;
   localparam logic [2:0] REG_CTRL = 3'd3;
   localparam logic [2:0] REG_STAT = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_GAP   = 2'd3
   } eng_state_e;
endpackage

// File: rtl/dma_mover_regs.sv
module dma_mover_regs
   import dma_mover_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32,
   parameter int unsigned LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          busy_i,
   input  logic          done_i,
   output logic          start_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [LW-1:0] len_o,
   output logic          dir_o,
   output logic [1:0]    mode_o,
   output logic          irq_o
);
   logic [AW-1:0] src_q, dst_q;
   logic [LW-1:0] len_q;
   logic          dir_q, irq_q;
   logic [1:0]    mode_q;
   logic          ctrl_wr, irq_clr;

   assign ctrl_wr = reg_we && (reg_addr == REG_CTRL) && !busy_i;
   assign irq_clr = reg_we && (reg_addr == REG_STAT) && reg_wdata[1];
   assign start_o = ctrl_wr && reg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         dir_q  <= 1'b0;
         mode_q <= XFER_HOLD;
         irq_q  <= 1'b0;
      end else begin
         if (reg_we && reg_addr == REG_SRC) src_q <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == REG_DST) dst_q <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == REG_LEN) len_q <= reg_wdata[LW-1:0];
         if (ctrl_wr) begin
            dir_q  <= reg_wdata[1];
            mode_q <= reg_wdata[3:2];
         end
         if (done_i)       irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_SRC:  reg_rdata = DW'(src_q);
         REG_DST:  reg_rdata = DW'(dst_q);
         REG_LEN:  reg_rdata = DW'(len_q);
         REG_CTRL: reg_rdata = DW'({mode_q, dir_q, 1'b0});
         REG_STAT: reg_rdata = DW'({irq_q, busy_i});
         default:  reg_rdata = '0;
      endcase
   end

   assign src_o  = src_q;
   assign dst_o  = dst_q;
   assign len_o  = len_q;
   assign dir_o  = dir_q;
   assign mode_o = mode_q;
   assign irq_o  = irq_q;
endmodule

// File: rtl/dma_mover_policy.sv
module dma_mover_policy
   import dma_mover_pkg::*;
#(
   parameter bit IDLECYC_EN = 1'b1
) (
   input  eng_state_e state_i,
   input  logic [1:0] mode_i,
   input  logic       bus_gnt,
   input  logic       cpu_busy,
   output logic       bus_req,
   output logic       allow_o
);
   assign bus_req = (state_i == ST_READ) || (state_i == ST_WRITE);

   generate
      if (IDLECYC_EN) begin : g_idlecyc
         assign allow_o = bus_gnt && !((mode_i == XFER_IDLECYC) && cpu_busy);
      end else begin : g_no_idlecyc
         logic unused_busy;
         assign unused_busy = cpu_busy ^ mode_i[0];
         assign allow_o = bus_gnt;
      end
   endgenerate
endmodule

// File: rtl/dma_mover_engine.sv
module dma_mover_engine
   import dma_mover_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32,
   parameter int unsigned LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [LW-1:0] len_i,
   input  logic          dir_i,
   input  logic [1:0]    mode_i,
   input  logic          allow_i,
   input  logic [DW-1:0] mem_rdata,
   output eng_state_e    state_o,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          done_o,
   output logic          busy_o
);
   localparam logic [LW-1:0] CNT_LAST = LW'(1);
   localparam logic [AW-1:0] ADDR_STEP = AW'(1);

   eng_state_e    state_q;
   logic [AW-1:0] src_q, dst_q;
   logic [LW-1:0] cnt_q;
   logic [DW-1:0] data_q;
   logic          last_word, zero_start;

   assign last_word  = (cnt_q == CNT_LAST);
   assign zero_start = (state_q == ST_IDLE) && start_i && (len_i == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i && len_i != '0) begin
               src_q   <= src_i;
               dst_q   <= dst_i;
               cnt_q   <= len_i;
               state_q <= ST_READ;
            end
            ST_READ: if (allow_i) begin
               data_q  <= mem_rdata;
               state_q <= ST_WRITE;
            end
            ST_WRITE: if (allow_i) begin
               cnt_q <= cnt_q - CNT_LAST;
               dst_q <= dst_q + ADDR_STEP;
               if (!dir_i) src_q <= src_q + ADDR_STEP;
               if (last_word)                 state_q <= ST_IDLE;
               else if (mode_i == XFER_STEAL) state_q <= ST_GAP;
               else                           state_q <= ST_READ;
            end
            ST_GAP:  state_q <= ST_READ;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd    = (state_q == ST_READ) && allow_i;
   assign mem_wr    = (state_q == ST_WRITE) && allow_i;
   assign mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
   assign mem_wdata = data_q;
   assign done_o    = zero_start || (mem_wr && last_word);
   assign busy_o    = (state_q != ST_IDLE);
   assign state_o   = state_q;
endmodule

// File: rtl/dma_mover.sv
module dma_mover
   import dma_mover_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32,
   parameter int unsigned LW = 8,
   parameter bit          IDLECYC_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   input  logic          cpu_busy,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          irq
);
   generate
      if (DW < AW || DW < LW || DW < 4) begin : g_bad_width
         $error("dma_mover: DW must cover AW, LW and the control field");
      end
      if (LW < 1 || AW < 1) begin : g_bad_size
         $error("dma_mover: AW and LW must be at least 1");
      end
   endgenerate

   logic          start, done, busy, dir, allow;
   logic [AW-1:0] src, dst;
   logic [LW-1:0] len;
   logic [1:0]    cfg_mode;
   eng_state_e    state;

   dma_mover_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
      .done_i(done), .start_o(start), .src_o(src), .dst_o(dst),
      .len_o(len), .dir_o(dir), .mode_o(cfg_mode), .irq_o(irq)
   );

   dma_mover_policy #(.IDLECYC_EN(IDLECYC_EN)) u_policy (
      .state_i(state), .mode_i(cfg_mode), .bus_gnt(bus_gnt),
      .cpu_busy(cpu_busy), .bus_req(bus_req), .allow_o(allow)
   );

   dma_mover_engine #(.AW(AW), .DW(DW), .LW(LW)) u_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src), .dst_i(dst),
      .len_i(len), .dir_i(dir), .mode_i(cfg_mode), .allow_i(allow),
      .mem_rdata(mem_rdata), .state_o(state), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .done_o(done), .busy_o(busy)
   );
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk
   import dma_mover_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic       cpu_busy,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       irq,
   input logic [1:0] mode,
   input logic       reg_we,
   input logic [2:0] reg_addr,
   input logic       clr_bit
);
   logic clr_req;
   assign clr_req = reg_we && (reg_addr == REG_STAT) && clr_bit;

   assert_no_access_without_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> bus_gnt);

   assert_req_held_until_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);

   assert_idle_slot_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_IDLECYC && cpu_busy) |-> !(mem_rd || mem_wr));

   assert_steal_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_STEAL && mem_wr) |=> !bus_req);

   assert_hold_keeps_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_HOLD && $fell(bus_req)) |-> $past(mem_wr));

   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_req) |=> irq);

   assert_read_write_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
endmodule

bind dma_mover dma_mover_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .cpu_busy(cpu_busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq),
   .mode(cfg_mode), .reg_we(reg_we), .reg_addr(reg_addr),
   .clr_bit(reg_wdata[1])
);

// File: tb/dma_mover_tb.sv
module dma_mover_tb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LW = 8;
   localparam int NVEC = 6;
   // {mode[26:25], dir[24], src[23:16], dst[15:8], len[7:0]}
   localparam logic [26:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 8'h10, 8'h80, 8'd5},
      {2'd1, 1'b0, 8'h20, 8'h90, 8'd4},
      {2'd2, 1'b0, 8'h30, 8'hA0, 8'd6},
      {2'd0, 1'b1, 8'h40, 8'hB0, 8'd3},
      {2'd1, 1'b1, 8'h44, 8'hC0, 8'd2},
      {2'd2, 1'b1, 8'h48, 8'hD0, 8'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          bus_req, mem_rd, mem_wr, irq;
   logic          bus_gnt = 1'b0;
   logic          cpu_busy = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   logic [DW-1:0] mem [256];
   logic          gnt_block = 1'b0;
   logic          busy_en = 1'b0;
   int            cyc = 0;
   int            checks = 0, errors = 0;
   int            mon_rd = 0, mon_wr = 0, mon_rise = 0, mon_viol = 0, mon_nogrant = 0;
   logic          prev_req = 1'b0;

   always #2 clk = ~clk;

   dma_mover #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .cpu_busy(cpu_busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
   );

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      cyc      <= cyc + 1;
      bus_gnt  <= bus_req && !gnt_block;
      cpu_busy <= busy_en && ((cyc % 3) != 0);
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   always @(negedge clk) begin
      if (mem_rd) mon_rd = mon_rd + 1;
      if (mem_wr) mon_wr = mon_wr + 1;
      if (bus_req && !prev_req) mon_rise = mon_rise + 1;
      if (cpu_busy && (mem_rd || mem_wr)) mon_viol = mon_viol + 1;
      if ((mem_rd || mem_wr) && !bus_gnt) mon_nogrant = mon_nogrant + 1;
      prev_req = bus_req;
   end

   function automatic logic [DW-1:0] pat(input int a);
      return 32'h5A00_0000 + (a * 32'h0001_0203);
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic mem_init();
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
   endtask

   task automatic mon_clear();
      mon_rd = 0; mon_wr = 0; mon_rise = 0; mon_viol = 0; mon_nogrant = 0;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 500) begin
         @(negedge clk);
         n++;
      end
      check(req, {31'd0, irq}, 32'd1);
   endtask

   logic [DW-1:0] rd;

   initial begin
      mem_init();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state R10
      reg_read(3'd4, rd);
      check("R10 status after reset", rd, 32'd0);
      check("R10 irq after reset", {31'd0, irq}, 32'd0);
      check("R10 bus_req after reset", {31'd0, bus_req}, 32'd0);

      // R1 readback and R2 no transfer without start
      mon_clear();
      reg_write(3'd0, 32'h0000_1234);
      reg_write(3'd1, 32'h0000_00F0);
      reg_write(3'd2, 32'h0000_0007);
      repeat (8) @(negedge clk);
      reg_read(3'd0, rd); check("R1 src readback", rd, 32'h1234);
      reg_read(3'd1, rd); check("R1 dst readback", rd, 32'h00F0);
      reg_read(3'd2, rd); check("R1 len readback", rd, 32'h0007);
      check("R2 no request", {31'd0, bus_req}, 32'd0);
      check("R2 no access", 32'(mon_rd + mon_wr), 32'd0);

      // vector table: R3 R4 R5 R8 R12 R6
      foreach (VEC[v]) begin
         logic [1:0] md = VEC[v][26:25];
         logic       dr = VEC[v][24];
         int sa = int'(VEC[v][23:16]);
         int da = int'(VEC[v][15:8]);
         int ln = int'(VEC[v][7:0]);
         int bad = 0;
         int exp_rise;
         mem_init();
         busy_en = (md == 2'd2);
         reg_write(3'd0, 32'(sa));
         reg_write(3'd1, 32'(da));
         reg_write(3'd2, 32'(ln));
         mon_clear();
         reg_write(3'd3, {28'd0, md, dr, 1'b1});
         wait_irq("R6 irq after block");
         @(negedge clk);
         busy_en = 1'b0;
         for (int i = 0; i < ln; i++)
            if (mem[da + i] !== pat(dr ? sa : sa + i)) bad++;
         check("R8 R12 destination data", 32'(bad), 32'd0);
         check("R8 guard word untouched", mem[da + ln], pat(da + ln));
         check("R12 read count", 32'(mon_rd), 32'(ln));
         exp_rise = (md == 2'd1) ? ln : 1;
         check(md == 2'd1 ? "R4 steal request rises" : "R3 hold request rises",
               32'(mon_rise), 32'(exp_rise));
         if (md == 2'd2) check("R5 access during cpu_busy", 32'(mon_viol), 32'd0);
         check("R9 access without grant", 32'(mon_nogrant), 32'd0);
         reg_write(3'd4, 32'h2);
         check("R6 irq cleared by write-one", {31'd0, irq}, 32'd0);
      end

      // R7 zero count
      mem_init();
      mon_clear();
      reg_write(3'd2, 32'd0);
      reg_write(3'd3, {28'd0, 2'd0, 1'b0, 1'b1});
      check("R7 irq on zero count", {31'd0, irq}, 32'd1);
      repeat (4) @(negedge clk);
      check("R7 no access on zero count", 32'(mon_rd + mon_wr + mon_rise), 32'd0);
      reg_read(3'd4, rd);
      check("R7 status irq set busy clear", rd, 32'd2);
      reg_write(3'd4, 32'h1);
      check("R6 write of zero to bit 1 keeps irq", {31'd0, irq}, 32'd1);
      reg_write(3'd4, 32'h2);

      // R9 grant withheld
      mem_init();
      gnt_block = 1'b1;
      reg_write(3'd0, 32'h18);
      reg_write(3'd1, 32'h70);
      reg_write(3'd2, 32'd2);
      mon_clear();
      reg_write(3'd3, {28'd0, 2'd0, 1'b0, 1'b1});
      repeat (6) @(negedge clk);
      check("R9 request held without grant", {31'd0, bus_req}, 32'd1);
      check("R9 no access before grant", 32'(mon_rd + mon_wr), 32'd0);
      gnt_block = 1'b0;
      wait_irq("R9 completes after grant");
      @(negedge clk);
      check("R9 data after grant", mem[8'h71], pat(8'h19));
      reg_write(3'd4, 32'h2);

      // R10 busy and R11 start while busy ignored
      mem_init();
      reg_write(3'd0, 32'h10);
      reg_write(3'd1, 32'h60);
      reg_write(3'd2, 32'd8);
      mon_clear();
      reg_write(3'd3, {28'd0, 2'd1, 1'b0, 1'b1});
      repeat (3) @(negedge clk);
      reg_read(3'd4, rd);
      check("R10 busy mid-block", rd & 32'h1, 32'h1);
      reg_write(3'd3, {28'd0, 2'd0, 1'b1, 1'b1});
      reg_read(3'd3, rd);
      check("R11 control unchanged", rd, 32'h4);
      wait_irq("R11 irq after first block");
      @(negedge clk);
      check("R11 read count unchanged", 32'(mon_rd), 32'd8);
      check("R11 last word stepped", mem[8'h67], pat(8'h17));
      reg_read(3'd4, rd);
      check("R10 busy clear after completion", rd & 32'h1, 32'h0);
      repeat (6) @(negedge clk);
      check("R11 no restart", 32'(mon_rd), 32'd8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule